// File: doc/BRIEF.md
# Semiring Tile Matrix Multiplier

This block multiplies two small square integer tiles and folds the product into a third tile. It computes D = C ⊕ (A ⊗ B). Each operation selects the pair of operators: the element-wise combine operator ⊗ and the reducing operator ⊕. Four pairs are available: ordinary multiply with add, saturating add with signed minimum, saturating add with signed maximum, and single-bit AND with OR. Path-finding, scheduling and reachability kernels therefore run on the same array that serves linear algebra.

A client presents the A, B and C tiles together with a 2-bit mode, and pulses `start`. The block captures the operands and the mode, and performs one reduction step per clock for every element of the tile at once. After N steps it raises `done` for one cycle and presents the finished D tile. That tile stays on the output until the next operation completes. A new operation may be started in the same cycle as `done`, so operations can run back to back.

Top module: `sr_matmul_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every bit of `d_tile` is 0.
- R2: A `start` seen while `busy` is 0 is accepted. `busy` is 1 from the next cycle on. `done` is 1 for exactly one cycle, N clock edges after the accepting edge, and `busy` is 0 in that cycle.
- R3: A `start` seen while `busy` is 1 is ignored. It affects neither the timing nor the result of the running operation.
- R4: Mode 00 gives D[i][j] = C[i][j] + Σk A[i][k]·B[k][j], taken modulo 2^W. Element (i,j) of a tile occupies bits [(i·N+j)·W +: W].
- R5: Mode 01 (min-plus) gives D[i][j] = min(C[i][j], mink(A[i][k]+B[k][j])), with all values read as signed two's complement.
- R6: Mode 10 (max-plus) gives D[i][j] = max(C[i][j], maxk(A[i][k]+B[k][j])), with all values read as signed.
- R7: Mode 11 uses only bit 0 of each element. It gives D[i][j] = C[i][j] | ORk(A[i][k] & B[k][j]), with bits W-1..1 of every D element equal to 0.
- R8: The mode and the A and B tiles are captured at the accepting edge. Changes on those inputs while `busy` is 1 have no effect on the result.
- R9: `d_tile` changes only at the edge that raises `done`. It holds its value in every other cycle.
- R10: A `start` presented in the cycle where `done` is 1 is accepted. Its `done` follows N edges later.
- R11: In modes 01 and 10, A[i][k]+B[k][j] saturates to 2^(W-1)-1 or -2^(W-1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| mode | input | 2 | Operator pair: 00 mul/add, 01 min-plus, 10 max-plus, 11 and/or |
| a_tile | input | N·N·W | Left operand tile, row-major |
| b_tile | input | N·N·W | Right operand tile, row-major |
| c_tile | input | N·N·W | Accumulate-into tile, row-major |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_tile | output | N·N·W | Result tile, row-major |

## Verification
Two events can fall on the same edge: the completion of one operation (the `done` pulse and the update of `d_tile`) and the acceptance of the next `start`. The bench provokes this by holding `start` high across several operations while randomising mode and operands in every cycle, and by issuing a `start` during the last reduction step. A behavioural model, evaluated every clock, decides which requests are accepted. Each accepted request must produce exactly one `done` N edges later, carrying the result computed from the operands captured at acceptance. Requests that are refused must leave no trace.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [1:0] {
      SR_MULADD  = 2'b00,
      SR_MINPLUS = 2'b01,
      SR_MAXPLUS = 2'b10,
      SR_ANDOR   = 2'b11
   } sr_mode_e;
endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic [IW-1:0] step_idx,
   output logic          load,
   output logic          step,
   output logic          fin
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   assign load = start && !busy;
   assign step = busy;
   assign fin  = busy && (step_idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         step_idx <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (step_idx == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step_idx <= step_idx + 1'b1;
            end
         end else if (start) begin
            busy     <= 1'b1;
            step_idx <= '0;
         end
      end
   end

   // R2: accepted start makes the unit busy on the next cycle
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R2: completion pulse is one cycle wide and only follows a busy cycle
   p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R3: while busy the step index only advances by one
   p_ignore_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (step_idx == $past(step_idx) + 1'b1));
endmodule

// File: rtl/sr_cell.sv
module sr_cell
   import sr_pkg::*;
#(
   parameter int W       = 8,
   parameter bit SAT_ADD = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  sr_mode_e     mode,
   input  logic [W-1:0] init,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] acc,
   output logic [W-1:0] acc_nxt
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0]   wide_sum;
   logic [W-1:0] plus_v;
   logic [W-1:0] prod_v;
   logic [W-1:0] init_v;

   assign wide_sum = {opa[W-1], opa} + {opb[W-1], opb};
   assign prod_v   = opa * opb;

   generate
      if (SAT_ADD) begin : g_sat
         always_comb begin
            if (wide_sum[W] != wide_sum[W-1])
               plus_v = wide_sum[W] ? SMIN : SMAX;
            else
               plus_v = wide_sum[W-1:0];
         end
      end else begin : g_wrap
         assign plus_v = wide_sum[W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (mode)
         SR_MULADD:  acc_nxt = acc + prod_v;
         SR_MINPLUS: acc_nxt = ($signed(plus_v) < $signed(acc)) ? plus_v : acc;
         SR_MAXPLUS: acc_nxt = ($signed(plus_v) > $signed(acc)) ? plus_v : acc;
         default:    acc_nxt = {{(W-1){1'b0}}, acc[0] | (opa[0] & opb[0])};
      endcase
   end

   assign init_v = (mode == SR_ANDOR) ? {{(W-1){1'b0}}, init[0]} : init;

   always_ff @(posedge clk) begin
      if (!rst_n)    acc <= '0;
      else if (load) acc <= init_v;
      else if (step) acc <= acc_nxt;
   end

   // R5: a min-plus step never raises the running value
   p_min_nonrising_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && mode == SR_MINPLUS) |=> ($signed(acc) <= $signed($past(acc))));
   // R6: a max-plus step never lowers the running value
   p_max_nonfalling_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && mode == SR_MAXPLUS) |=> ($signed(acc) >= $signed($past(acc))));
   // R7: logical mode keeps upper bits clear
   p_logic_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((load || step) && mode == SR_ANDOR) |=> (acc[W-1:1] == '0));
endmodule

// File: rtl/sr_matmul_unit.sv
module sr_matmul_unit
   import sr_pkg::*;
#(
   parameter int N       = 4,
   parameter int W       = 8,
   parameter bit SAT_ADD = 1'b1,
   localparam int TB     = N * N * W,
   localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [TB-1:0] a_tile,
   input  logic [TB-1:0] b_tile,
   input  logic [TB-1:0] c_tile,
   output logic          busy,
   output logic          done,
   output logic [TB-1:0] d_tile
);
   generate
      if (N < 2 || N > 16) begin : g_bad_n
         $error("sr_matmul_unit: N must lie in 2..16");
      end
      if (W < 2) begin : g_bad_w
         $error("sr_matmul_unit: W must be at least 2");
      end
   endgenerate

   logic [TB-1:0] a_q, b_q, d_q, nxt_all;
   sr_mode_e      mode_q, mode_sel;
   logic [IW-1:0] step_idx;
   logic          load, step, fin;

   sr_ctrl #(.N(N)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .step_idx(step_idx),
      .load(load), .step(step), .fin(fin)
   );

   assign mode_sel = busy ? mode_q : sr_mode_e'(mode);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= SR_MULADD;
         d_q    <= '0;
      end else begin
         if (load) begin
            a_q    <= a_tile;
            b_q    <= b_tile;
            mode_q <= sr_mode_e'(mode);
         end
         if (fin) d_q <= nxt_all;
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_row
         for (genvar j = 0; j < N; j++) begin : g_col
            logic [W-1:0] opa, opb, acc;
            assign opa = a_q[(i*N + int'(step_idx))*W +: W];
            assign opb = b_q[(int'(step_idx)*N + j)*W +: W];
            sr_cell #(.W(W), .SAT_ADD(SAT_ADD)) u_cell (
               .clk(clk), .rst_n(rst_n), .load(load), .step(step),
               .mode(mode_sel), .init(c_tile[(i*N+j)*W +: W]),
               .opa(opa), .opb(opb), .acc(acc),
               .acc_nxt(nxt_all[(i*N+j)*W +: W])
            );
         end
      end
   endgenerate

   assign d_tile = d_q;

   // R9: result only moves on the completion edge
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(d_tile));
   // R8: captured mode stays fixed while an operation runs
   p_mode_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));
endmodule

// File: tb/sr_matmul_unit_bench.sv
`timescale 1ns/1ps
module sr_matmul_unit_bench;
   localparam int N  = 4;
   localparam int W  = 8;
   localparam int TB = N * N * W;
   localparam int SMAXI = (1 << (W-1)) - 1;
   localparam int SMINI = -(1 << (W-1));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [TB-1:0] a_tile = '0, b_tile = '0, c_tile = '0;
   logic          busy, done;
   logic [TB-1:0] d_tile;

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   // behavioural model state
   bit            m_busy = 1'b0, m_done = 1'b0;
   int            m_cnt = 0;
   logic [TB-1:0] m_pend = '0, m_d = '0;

   always #2 clk = ~clk;

   sr_matmul_unit #(.N(N), .W(W)) u_sr_matmul_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .a_tile(a_tile), .b_tile(b_tile), .c_tile(c_tile),
      .busy(busy), .done(done), .d_tile(d_tile)
   );

   function automatic int el(input logic [TB-1:0] t, input int idx);
      logic signed [W-1:0] v;
      v = t[idx*W +: W];
      return int'(v);
   endfunction

   function automatic logic [TB-1:0] ref_mm(input logic [1:0] md,
         input logic [TB-1:0] a, input logic [TB-1:0] b, input logic [TB-1:0] c);
      logic [TB-1:0] r;
      r = '0;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            int acc;
            acc = el(c, i*N + j);
            if (md == 2'b11) acc = acc & 1;
            for (int k = 0; k < N; k++) begin
               int x, y, s;
               x = el(a, i*N + k);
               y = el(b, k*N + j);
               s = x + y;
               if (s > SMAXI) s = SMAXI;
               if (s < SMINI) s = SMINI;
               case (md)
                  2'b00: acc = acc + x * y;
                  2'b01: if (s < acc) acc = s;
                  2'b10: if (s > acc) acc = s;
                  default: acc = acc | (x & y & 1);
               endcase
            end
            r[(i*N+j)*W +: W] = acc[W-1:0];
         end
      end
      return r;
   endfunction

   function automatic logic [TB-1:0] rnd_tile();
      logic [TB-1:0] t;
      for (int i = 0; i < N*N; i++) t[i*W +: W] = W'($urandom);
      return t;
   endfunction

   function automatic logic [TB-1:0] fill(input logic [W-1:0] v);
      logic [TB-1:0] t;
      for (int i = 0; i < N*N; i++) t[i*W +: W] = v;
      return t;
   endfunction

   task automatic chk1(input string req, input string what, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
      end
   endtask

   // one clock: drive inputs, advance model at the edge, compare at the falling edge
   task automatic cycle(input bit st, input logic [1:0] md, input logic [TB-1:0] a,
         input logic [TB-1:0] b, input logic [TB-1:0] c, input string req);
      bit ob;
      start = st; mode = md; a_tile = a; b_tile = b; c_tile = c;
      @(posedge clk);
      ob = m_busy;
      m_done = 1'b0;
      if (!rst_n) begin
         m_busy = 1'b0; m_cnt = 0; m_d = '0;
      end else begin
         if (ob) begin
            if (m_cnt == N-1) begin
               m_busy = 1'b0; m_done = 1'b1; m_d = m_pend;
            end else m_cnt++;
         end
         if (st && !ob) begin
            m_pend = ref_mm(md, a, b, c); m_busy = 1'b1; m_cnt = 0;
         end
      end
      @(negedge clk);
      chk1((req == "R1") ? "R1" : "R2", "busy", busy, m_busy);
      chk1((req == "R1") ? "R1" : "R2", "done", done, m_done);
      n_cmp++;
      if (d_tile !== m_d) begin
         n_bad++;
         $display("FAIL %s d_tile: actual %h expected %h", req, d_tile, m_d);
      end
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++)
         cycle(1'b0, 2'($urandom), rnd_tile(), rnd_tile(), rnd_tile(), req);
   endtask

   // start one operation; in the following busy cycles optionally press start and scramble inputs
   task automatic op(input logic [1:0] md, input logic [TB-1:0] a, input logic [TB-1:0] b,
         input logic [TB-1:0] c, input bit noisy, input string req);
      cycle(1'b1, md, a, b, c, req);
      for (int i = 0; i < N; i++)
         cycle(noisy && (i < N-1) ? 1'b1 : 1'b0, 2'($urandom), rnd_tile(), rnd_tile(), rnd_tile(), req);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) cycle(1'b1, 2'b00, rnd_tile(), rnd_tile(), rnd_tile(), "R1");
      rst_n = 1'b1;
      idle(2, "R1");
      // R4..R7 per mode, quiet and noisy busy phases
      for (int r = 0; r < 3; r++) begin
         op(2'b00, rnd_tile(), rnd_tile(), rnd_tile(), r[0], "R4");
         op(2'b01, rnd_tile(), rnd_tile(), rnd_tile(), r[0], "R5");
         op(2'b10, rnd_tile(), rnd_tile(), rnd_tile(), r[0], "R6");
         op(2'b11, rnd_tile(), rnd_tile(), rnd_tile(), r[0], "R7");
         idle(1, "R9");
      end
      // R3 and R8: start pressed and inputs scrambled while busy
      for (int r = 0; r < 4; r++) op(2'(r), rnd_tile(), rnd_tile(), rnd_tile(), 1'b1, "R3");
      for (int r = 0; r < 4; r++) op(2'(3 - r), rnd_tile(), rnd_tile(), rnd_tile(), 1'b1, "R8");
      // R11: sums that wrap would pick the wrong extreme
      op(2'b01, fill(8'h7F), fill(8'h01), fill(8'h7F), 1'b0, "R11");
      op(2'b10, fill(8'h80), fill(8'hFF), fill(8'h80), 1'b0, "R11");
      op(2'b01, fill(8'h80), fill(8'h80), fill(8'h00), 1'b0, "R11");
      op(2'b10, fill(8'h7F), fill(8'h7F), fill(8'h00), 1'b0, "R11");
      // R10: start held high so each done cycle also accepts the next request
      for (int i = 0; i < 5 * (N + 1); i++)
         cycle(1'b1, 2'($urandom), rnd_tile(), rnd_tile(), rnd_tile(), "R10");
      // R9: long idle with moving inputs
      idle(8, "R9");
      summary();
      $finish;
   end
endmodule